// File: doc/BRIEF.md
# Serial Line Autobaud Detector

This block watches an idle-high asynchronous serial receive line and measures how many system clocks one bit lasts. It needs no prior knowledge of the system clock frequency. It re-times the line through a short synchronizer and measures two intervals. The first runs from one falling edge to the next. The second runs from one rising edge to the next. Whenever a rising edge arrives, the block checks the newest pair of intervals against the shape of an ASCII space character (0x20) sent as 8N1. In that character the falling edges are seven bit times apart and the rising edges are three bit times apart.

Both intervals are scaled onto a common 21-bit-time scale and compared with a tolerance of about one part in sixteen. The bit period is taken from the scaled fall-to-fall product. Until the first match, every candidate is handed to the companion receiver as soon as it is formed, before the verdict is known. After the first match the block is locked. From then on, only further space characters change the bit period, and each one raises a retrim strobe. Interval pairs that were captured out of phase, which happens after reset is released in the middle of a character, fail the ratio test and are dropped. The block then keeps waiting.

Top module: `ab_autobaud`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `bit_clocks` is 0 and `clocks_load`, `lock_pulse`, `retrim_pulse` and `locked` are all 0.
- R2: `rx_in` passes through a two-stage synchronizer. Take the clock edge that first samples the rising edge ending a pair. The candidate appears on `bit_clocks` with `clocks_load` at the fourth edge after it. The verdict strobe (`lock_pulse` or `retrim_pulse`) appears at the fifth edge after it.
- R3: At every synchronized rising edge, one pair is evaluated. It holds the fall-to-fall interval that most recently finished before that rising edge, and the rise-to-rise interval that ends at that rising edge. An interval is the number of clock edges between its two detected edges.
- R4: The fall-to-fall count is scaled by 9362 and the rise-to-rise count by 21845. The pair is accepted only if the absolute difference of the two products, shifted right by (index of the highest set bit of the scaled fall-to-fall product minus 4), is zero.
- R5: The bit-period estimate is bits 31:16 of the scaled fall-to-fall product. For a clean space character with B clocks per bit, this is (7·B·9362)>>16.
- R6: Before lock, every evaluated pair drives its estimate onto `bit_clocks` with a one-cycle `clocks_load`, whether or not it is later accepted. `bit_clocks` changes only in a cycle where `clocks_load` is high.
- R7: The first accepted pair raises `lock_pulse` for one cycle and sets `locked`. `locked` then stays high until reset, and `lock_pulse` never fires again.
- R8: While locked, each accepted pair loads its estimate with `clocks_load` and one `retrim_pulse`. Rejected pairs, such as characters 0x41 or 0x55, leave `bit_clocks` unchanged and raise no strobe.
- R9: Pairs that straddle a character boundary are rejected. This covers back-to-back space characters and a reset released mid-character. After a mid-character reset release, no lock occurs until a complete space character arrives.
- R10: Both interval counters saturate at 2^CNT_W−1. A pair holding a saturated interval is always rejected, so an idle line never locks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| bit_clocks | output | 16 | Estimated system clocks per serial bit |
| clocks_load | output | 1 | One-cycle strobe: `bit_clocks` has just been loaded |
| lock_pulse | output | 1 | One-cycle strobe on the first accepted space character |
| retrim_pulse | output | 1 | One-cycle strobe on each later accepted space character |
| locked | output | 1 | High once a bit period has been accepted |

## Verification
Suppose the held fall-to-fall value were taken from the wrong edge. A clean space character would then be rejected, and the missing `lock_pulse` would show five edges after the stop-bit rise is sampled. A fault in the scaling or the bit slice shows up as a wrong `bit_clocks` value at the next `clocks_load`, one edge before the verdict. Counters that wrap instead of saturating let a long idle gap alias into a plausible pair. That error appears as an early lock or a wrong candidate on the first character after the gap. A reference model compares every output on every clock, so a fault is reported in the cycle it first reaches a port.

// File: rtl/ab_pkg.sv
`timescale 1ns/1ps
package ab_pkg;
    localparam int unsigned CPB_W      = 16;
    localparam int unsigned NORM_SHIFT = 16;
    // Both intervals are scaled onto a 21-bit-time scale (7 fall-to-fall, 3 rise-to-rise)
    localparam int unsigned NORM_FF    = (3 * (1 << NORM_SHIFT)) / 21;
    localparam int unsigned NORM_RR    = (7 * (1 << NORM_SHIFT)) / 21;
    localparam int unsigned TOL_SHIFT  = 4;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_TRACK = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic             vld;
        logic             accept;
        logic [CPB_W-1:0] cpb;
    } verdict_t;

    // Index of the highest set bit; 0 when the value is 0
    function automatic logic [6:0] top_bit(input logic [63:0] v);
        logic [6:0] p;
        p = '0;
        for (int i = 0; i < 64; i++) begin
            if (v[i]) p = 7'(i);
        end
        return p;
    endfunction

    // Bits 31:16 of the scaled fall-to-fall product, clamped if larger
    function automatic logic [CPB_W-1:0] cpb_of(input logic [63:0] nff);
        if (|nff[63:NORM_SHIFT+CPB_W]) return '1;
        return nff[NORM_SHIFT+CPB_W-1:NORM_SHIFT];
    endfunction
endpackage

// File: rtl/ab_sync_edge.sv
`timescale 1ns/1ps
module ab_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_in,
    output logic rise,
    output logic fall
);
    // sh[STAGES-1] is the re-timed line, sh[STAGES] its previous value (R2)
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-1:0], rx_in};
    end

    assign rise =  sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/ab_interval_timer.sv
`timescale 1ns/1ps
module ab_interval_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             fall,
    output logic             pair_vld,
    output logic [CNT_W-1:0] pair_ff,
    output logic [CNT_W-1:0] pair_rr
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [1:0]       edge_v;
    logic [CNT_W-1:0] fall_age;
    logic [CNT_W-1:0] rise_age;
    logic [CNT_W-1:0] ff_last;

    assign edge_v = {rise, fall};

    // One saturating age counter per edge polarity (R10)
    for (genvar g = 0; g < 2; g++) begin : g_age
        logic [CNT_W-1:0] age;
        always_ff @(posedge clk) begin
            if (rst)                 age <= CNT_MAX;
            else if (edge_v[g])      age <= CNT_W'(1);
            else if (age != CNT_MAX) age <= age + 1'b1;
        end
    end

    assign fall_age = g_age[0].age;
    assign rise_age = g_age[1].age;

    // Completed fall-to-fall held until the next rise takes it (R3)
    always_ff @(posedge clk) begin
        if (rst)       ff_last <= CNT_MAX;
        else if (fall) ff_last <= fall_age;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_vld <= 1'b0;
            pair_ff  <= CNT_MAX;
            pair_rr  <= CNT_MAX;
        end else begin
            pair_vld <= rise;
            if (rise) begin
                pair_ff <= ff_last;
                pair_rr <= rise_age;
            end
        end
    end
endmodule

// File: rtl/ab_ratio_check.sv
`timescale 1ns/1ps
module ab_ratio_check
    import ab_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [CNT_W-1:0] in_ff,
    input  logic [CNT_W-1:0] in_rr,
    output logic             cand_vld,
    output logic [CPB_W-1:0] cand_cpb,
    output verdict_t         verdict
);
    localparam int           PROD_W  = CNT_W + NORM_SHIFT;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic              b_vld;
    logic              b_bad;
    logic [PROD_W-1:0] b_nff;
    logic [PROD_W-1:0] b_nrr;
    logic [PROD_W-1:0] diff;
    logic [6:0]        msb;
    logic [6:0]        shamt;
    logic              ok;

    // Stage B: scale both intervals (R4), flag saturated ones (R10)
    always_ff @(posedge clk) begin
        if (rst) begin
            b_vld <= 1'b0;
            b_bad <= 1'b1;
            b_nff <= '0;
            b_nrr <= '0;
        end else begin
            b_vld <= in_vld;
            if (in_vld) begin
                b_bad <= (in_ff == CNT_MAX) || (in_rr == CNT_MAX);
                b_nff <= PROD_W'(in_ff) * PROD_W'(NORM_FF);
                b_nrr <= PROD_W'(in_rr) * PROD_W'(NORM_RR);
            end
        end
    end

    // Early candidate straight from the scaled product (R5, R6)
    assign cand_vld = b_vld;
    assign cand_cpb = cpb_of(64'(b_nff));

    // Stage C: tolerance test relative to magnitude (R4, R9)
    always_comb begin
        diff  = (b_nff >= b_nrr) ? (b_nff - b_nrr) : (b_nrr - b_nff);
        msb   = top_bit(64'(b_nff));
        shamt = (msb >= 7'(TOL_SHIFT)) ? (msb - 7'(TOL_SHIFT)) : 7'd0;
        ok    = !b_bad && ((diff >> shamt) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict <= '0;
        end else begin
            verdict.vld    <= b_vld;
            verdict.accept <= b_vld && ok;
            if (b_vld) verdict.cpb <= cand_cpb;
        end
    end
endmodule

// File: rtl/ab_autobaud.sv
`timescale 1ns/1ps
module ab_autobaud
    import ab_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_in,
    output logic [CPB_W-1:0] bit_clocks,
    output logic             clocks_load,
    output logic             lock_pulse,
    output logic             retrim_pulse,
    output logic             locked
);
    logic             rise;
    logic             fall;
    logic             pair_vld;
    logic [CNT_W-1:0] pair_ff;
    logic [CNT_W-1:0] pair_rr;
    logic             cand_vld;
    logic [CPB_W-1:0] cand_cpb;
    verdict_t         verdict;
    lock_state_e      state;

    ab_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .rx_in (rx_in),
        .rise  (rise),
        .fall  (fall)
    );

    ab_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .rise     (rise),
        .fall     (fall),
        .pair_vld (pair_vld),
        .pair_ff  (pair_ff),
        .pair_rr  (pair_rr)
    );

    ab_ratio_check #(.CNT_W(CNT_W)) u_ratio (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (pair_vld),
        .in_ff    (pair_ff),
        .in_rr    (pair_rr),
        .cand_vld (cand_vld),
        .cand_cpb (cand_cpb),
        .verdict  (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_HUNT;
            bit_clocks   <= '0;
            clocks_load  <= 1'b0;
            lock_pulse   <= 1'b0;
            retrim_pulse <= 1'b0;
        end else begin
            clocks_load  <= 1'b0;
            lock_pulse   <= 1'b0;
            retrim_pulse <= 1'b0;
            // Hunting: push every candidate before its verdict (R6)
            if (state == ST_HUNT && cand_vld) begin
                bit_clocks  <= cand_cpb;
                clocks_load <= 1'b1;
            end
            if (verdict.vld && verdict.accept) begin
                if (state == ST_HUNT) begin
                    state      <= ST_TRACK;       // R7
                    lock_pulse <= 1'b1;
                end else begin
                    bit_clocks   <= verdict.cpb;  // R8
                    clocks_load  <= 1'b1;
                    retrim_pulse <= 1'b1;
                end
            end
        end
    end

    assign locked = (state == ST_TRACK);
endmodule

// File: rtl/ab_autobaud_chk.sv
`timescale 1ns/1ps
module ab_autobaud_chk (
    input logic        clk,
    input logic        rst,
    input logic        pair_vld,
    input logic [15:0] bit_clocks,
    input logic        clocks_load,
    input logic        lock_pulse,
    input logic        retrim_pulse,
    input logic        locked
);
    AST_LOCK_ONCE: assert property (@(posedge clk) disable iff (rst)
        lock_pulse |-> (locked && !$past(locked)))
        else $error("lock strobe outside first lock"); // R7

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        $past(locked) |-> locked)
        else $error("lock dropped"); // R7

    AST_RETRIM_LOCKED: assert property (@(posedge clk) disable iff (rst)
        retrim_pulse |-> $past(locked))
        else $error("retrim before lock"); // R8

    AST_RETRIM_LOAD: assert property (@(posedge clk) disable iff (rst)
        retrim_pulse |-> clocks_load)
        else $error("retrim without load"); // R8

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lock_pulse, retrim_pulse}))
        else $error("two verdict strobes"); // R8

    AST_CPB_HOLD: assert property (@(posedge clk) disable iff (rst)
        !clocks_load |-> $stable(bit_clocks))
        else $error("bit period moved without load"); // R6

    AST_EARLY_PUSH: assert property (@(posedge clk) disable iff (rst)
        (pair_vld && !locked) |=> ##1 (clocks_load || locked))
        else $error("candidate not pushed while hunting"); // R6
endmodule

bind ab_autobaud ab_autobaud_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .pair_vld     (pair_vld),
    .bit_clocks   (bit_clocks),
    .clocks_load  (clocks_load),
    .lock_pulse   (lock_pulse),
    .retrim_pulse (retrim_pulse),
    .locked       (locked)
);

// File: tb/sim_ab_autobaud.sv
`timescale 1ns/1ps
module sim_ab_autobaud;
    localparam int  CW   = 12;
    localparam longint MAXC = (64'd1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_in = 1'b1;
    logic [15:0] bit_clocks;
    logic        clocks_load, lock_pulse, retrim_pulse, locked;

    int n_checks = 0;
    int n_err    = 0;
    int lock_seen = 0;
    int retrim_seen = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ab_autobaud #(.CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .rx_in(rx_in),
        .bit_clocks(bit_clocks), .clocks_load(clocks_load),
        .lock_pulse(lock_pulse), .retrim_pulse(retrim_pulse), .locked(locked)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit     h1 = 1, h2 = 1, h3 = 1;
    longint cyc = 0;
    bit     have_fall = 0, have_rise = 0;
    longint last_fall = 0, last_rise = 0, ff_hold = MAXC;
    longint cand_due = -1, ver_due = -1;
    int     cand_val = 0, ver_cpb = 0;
    bit     ver_acc = 0, m_locked = 0;
    int     e_cpb = 0;
    bit     e_load = 0, e_lock = 0, e_retrim = 0;

    function automatic longint interval(input bit have, input longint last, input longint now);
        if (!have) return MAXC;
        return (now - last > MAXC) ? MAXC : now - last;
    endfunction

    // Acceptance rule and estimate as stated in R4 and R5
    function automatic void judge(input longint ff, input longint rr, output bit acc, output int cpb);
        longint nff, nrr, diff;
        int pos, sh;
        nff = ff * 9362;
        nrr = rr * 21845;
        diff = (nff > nrr) ? nff - nrr : nrr - nff;
        pos = 0;
        for (int i = 0; i < 63; i++) if (nff[i]) pos = i;
        sh = (pos >= 4) ? pos - 4 : 0;
        acc = (ff != MAXC) && (rr != MAXC) && ((diff >> sh) == 0);
        cpb = ((nff >> 16) > 65535) ? 65535 : int'(nff >> 16);
    endfunction

    always @(posedge clk) begin
        bit rs, fl, a;
        int c;
        if (rst) begin
            h1 = 1; h2 = 1; h3 = 1; cyc = 0;
            have_fall = 0; have_rise = 0; ff_hold = MAXC;
            cand_due = -1; ver_due = -1; m_locked = 0;
            e_cpb = 0; e_load = 0; e_lock = 0; e_retrim = 0;
        end else begin
            cyc++;
            e_load = 0; e_lock = 0; e_retrim = 0;
            if (cand_due == cyc && !m_locked) begin
                e_cpb = cand_val; e_load = 1;
            end
            if (ver_due == cyc && ver_acc) begin
                if (!m_locked) begin m_locked = 1; e_lock = 1; end
                else begin e_retrim = 1; e_cpb = ver_cpb; e_load = 1; end
            end
            rs = h2 && !h3;
            fl = !h2 && h3;
            if (fl) begin
                ff_hold = interval(have_fall, last_fall, cyc);
                have_fall = 1; last_fall = cyc;
            end
            if (rs) begin
                judge(ff_hold, interval(have_rise, last_rise, cyc), a, c);
                have_rise = 1; last_rise = cyc;
                cand_val = c; cand_due = cyc + 2;
                ver_acc = a; ver_cpb = c; ver_due = cyc + 3;
            end
            h3 = h2; h2 = h1; h1 = rx_in;
        end
    end

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R5", "bit_clocks", bit_clocks, e_cpb);
            check("R6", "clocks_load", clocks_load, e_load);
            check("R2 R7", "lock_pulse", lock_pulse, e_lock);
            check("R8", "retrim_pulse", retrim_pulse, e_retrim);
            check("R7", "locked", locked, m_locked);
            if (lock_pulse) lock_seen++;
            if (retrim_pulse) retrim_seen++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(input logic v, input int n);
        rx_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input int bt, input int stretch5);
        drive(1'b0, bt);
        for (int i = 0; i < 8; i++) drive(b[i], bt + ((i == 5) ? stretch5 : 0));
        drive(1'b1, bt);
    endtask

    function automatic int est(input int ff);
        return int'((longint'(ff) * 9362) >> 16);
    endfunction

    initial begin
        int r0;
        repeat (5) @(negedge clk);
        check("R1", "bit_clocks in reset", bit_clocks, 0);
        check("R1", "locked in reset", locked, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "strobes after reset", {clocks_load, lock_pulse, retrim_pulse}, 0);

        drive(1'b1, 5000);                               // R10: idle past saturation
        check("R10", "no lock on idle line", locked, 0);

        send(8'h20, 16, 0); drive(1'b1, 10);             // R3 R5 R7: first lock
        check("R7", "locked after space", locked, 1);
        check("R5", "estimate at 16 clk/bit", bit_clocks, est(112));
        check("R7", "one lock strobe", lock_seen, 1);

        send(8'h41, 16, 0); drive(1'b1, 10);             // R8: other chars ignored
        send(8'h55, 16, 0); drive(1'b1, 10);
        check("R8", "estimate kept after 0x41/0x55", bit_clocks, est(112));
        check("R8", "no retrim on other chars", retrim_seen, 0);

        send(8'h20, 24, 0); drive(1'b1, 10);             // R8: retrim at new rate
        check("R8", "retrim at 24 clk/bit", bit_clocks, est(168));
        check("R8", "retrim count", retrim_seen, 1);
        check("R7", "still one lock strobe", lock_seen, 1);

        send(8'h20, 24, 1); drive(1'b1, 10);             // R4: small skew accepted
        check("R4", "skewed by 1 accepted", bit_clocks, est(169));
        send(8'h20, 24, 12); drive(1'b1, 10);            // R4: large skew rejected
        check("R4", "skewed by 12 rejected", bit_clocks, est(169));
        check("R4", "retrim count after skews", retrim_seen, 2);

        send(8'h20, 20, 0); send(8'h20, 20, 0); drive(1'b1, 10); // R9: back to back
        check("R9", "back-to-back retrims", retrim_seen, 4);
        check("R9", "estimate at 20 clk/bit", bit_clocks, est(140));

        @(negedge clk); rst = 1'b1; rx_in = 1'b0;        // R9: mid-character reset
        repeat (4) @(negedge clk);
        rst = 1'b0; r0 = lock_seen;
        drive(1'b0, 40); drive(1'b1, 20); drive(1'b0, 40); drive(1'b1, 30);
        check("R9", "no lock after partial char", locked, 0);
        send(8'h20, 10, 0); drive(1'b1, 10);
        check("R9", "lock after full space", locked, 1);
        check("R5", "estimate at 10 clk/bit", bit_clocks, est(70));
        check("R7", "lock strobe after reset", lock_seen - r0, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule